// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and delivers a signed product of `2*WIDTH` bits, presented as an upper and a lower half. A single double-width product register holds the partial product in its upper half and the multiplier in its lower half. A one-bit extension sits to the right of the lower half. On each cycle the lowest multiplier bit and the extension bit are recoded into add, subtract or no operation on the upper half. The whole register then shifts right by one place, keeping the sign.

A caller presents both operands with a one-cycle start strobe while the block is idle. The block raises busy for exactly `WIDTH` cycles, pulses done for one cycle when the last shift has completed, and then holds the product until the next accepted start. Because recoding and the arithmetic shift handle negative operands directly, no sign correction is applied before or after the run.

Top module: `booth_mul`

## Requirements
- R1: After reset, busy and done are 0 and both product halves are 0.
- R2: The recode pair is (current lowest multiplier bit, extension bit). Pair 01 adds the multiplicand into the upper half before the shift.
- R3: Pair 10 subtracts the multiplicand from the upper half before the shift.
- R4: Pairs 00 and 11 leave the upper half unchanged before the shift.
- R5: Each step shifts the whole register right by one with sign extension. The sum is formed one bit wider than the upper half, so the most negative multiplicand gives exact results (for example, -128 × -128 = 16384 at `WIDTH`=8).
- R6: A start strobe seen while idle is accepted. It latches both operands, clears the upper half and the extension bit, loads the multiplier into the lower half, and raises busy on the next cycle.
- R7: Busy stays high for exactly `WIDTH` cycles. Done is high for exactly one cycle, in the cycle after the last step, and busy is low in that cycle.
- R8: A start strobe while busy is ignored. New operand values at that time do not change the product of the run in progress.
- R9: While idle without a start strobe, the product halves stay unchanged. The upper half carries product bits 2*WIDTH-1..WIDTH and the lower half carries bits WIDTH-1..0.
- R10: At `WIDTH`=4, 2 × 7 yields 0000_1110 and 2 × (-3) yields 1111_1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only while idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | High while steps are in progress |
| done_o | output | 1 | One-cycle pulse after the final step |
| prod_hi_o | output | WIDTH | Upper half of the signed product |
| prod_lo_o | output | WIDTH | Lower half of the signed product |

## Verification
The bench targets the most negative multiplicand. If the sum were only as wide as the upper half, -128 × -128 or -128 × 127 would lose the sign and return a wrong upper half. Alternating bit patterns and all-ones multipliers exercise every recode pair. A swapped add/subtract, or a logical rather than arithmetic shift, shows up as a wrong product for negative multipliers. Other tests cover an off-by-one step count, which changes the busy length and the final scaling, and a start strobe accepted mid-run, which replaces the operands and corrupts the result.

// File: rtl/booth_pkg.sv
package booth_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2
    } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_i,
    input  logic      prev_i,
    output booth_op_e op_o
);
    always_comb begin
        unique case ({cur_i, prev_i})
            2'b01:   op_o = OP_ADD;   // R2: tail of a run of ones
            2'b10:   op_o = OP_SUB;   // R3: head of a run of ones
            default: op_o = OP_NOP;   // R4: inside a run
        endcase
    end
endmodule

// File: rtl/booth_addshift.sv
module booth_addshift
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    input  logic             ext_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  booth_op_e        op_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o,
    output logic             ext_o
);
    logic [WIDTH:0] acc_w;
    logic [WIDTH:0] addend_w;
    logic [WIDTH:0] sum_w;

    always_comb begin
        acc_w    = {hi_i[WIDTH-1], hi_i};
        addend_w = {mcand_i[WIDTH-1], mcand_i};
        unique case (op_i)
            OP_ADD:  sum_w = acc_w + addend_w;
            OP_SUB:  sum_w = acc_w - addend_w;
            default: sum_w = acc_w;
        endcase
        // R5: arithmetic right shift of the widened sum through the register
        hi_o  = sum_w[WIDTH:1];
        lo_o  = {sum_w[0], lo_i[WIDTH-1:1]};
        ext_o = lo_i[0];
    end
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] prod_hi_o,
    output logic [WIDTH-1:0] prod_lo_o
);
    localparam int CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] mcand;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic             ext;
    } state_t;

    state_t s_d, s_q;

    booth_op_e        op_w;
    logic [WIDTH-1:0] hi_n_w;
    logic [WIDTH-1:0] lo_n_w;
    logic             ext_n_w;

    booth_recode i_recode (
        .cur_i  (s_q.lo[0]),
        .prev_i (s_q.ext),
        .op_o   (op_w)
    );

    booth_addshift #(.WIDTH(WIDTH)) i_addshift (
        .hi_i    (s_q.hi),
        .lo_i    (s_q.lo),
        .ext_i   (s_q.ext),
        .mcand_i (s_q.mcand),
        .op_i    (op_w),
        .hi_o    (hi_n_w),
        .lo_o    (lo_n_w),
        .ext_o   (ext_n_w)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            s_d.hi  = hi_n_w;
            s_d.lo  = lo_n_w;
            s_d.ext = ext_n_w;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (start_i) begin
            s_d.busy  = 1'b1;
            s_d.cnt   = '0;
            s_d.mcand = mcand_i;
            s_d.hi    = '0;
            s_d.lo    = mplier_i;
            s_d.ext   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o    = s_q.busy;
    assign done_o    = s_q.done;
    assign prod_hi_o = s_q.hi;
    assign prod_lo_o = s_q.lo;

    assert_start_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i) |=> (s_q.busy && s_q.cnt == '0 && s_q.ext == 1'b0));

    assert_last_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt == LAST) |=> (s_q.done && !s_q.busy));

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(s_q.busy));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> $stable(s_q.mcand));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !start_i) |=> ($stable(s_q.hi) && $stable(s_q.lo)));

    assert_nop_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && (s_q.lo[0] == s_q.ext)) |=> (s_q.hi[WIDTH-2:0] == $past(s_q.hi[WIDTH-1:1])));
endmodule

// File: tb/test_booth_mul.sv
module test_booth_mul;
    localparam int W  = 8;
    localparam int W4 = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start8 = 1'b0;
    logic [W-1:0]  a8 = '0, b8 = '0;
    logic          busy8, done8;
    logic [W-1:0]  hi8, lo8;
    logic          start4 = 1'b0;
    logic [W4-1:0] a4 = '0, b4 = '0;
    logic          busy4, done4;
    logic [W4-1:0] hi4, lo4;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    booth_mul #(.WIDTH(W)) i_booth_mul (
        .clk(clk), .rst_n(rst_n), .start_i(start8), .mcand_i(a8), .mplier_i(b8),
        .busy_o(busy8), .done_o(done8), .prod_hi_o(hi8), .prod_lo_o(lo8));

    booth_mul #(.WIDTH(W4)) i_booth_mul_w4 (
        .clk(clk), .rst_n(rst_n), .start_i(start4), .mcand_i(a4), .mplier_i(b4),
        .busy_o(busy4), .done_o(done4), .prod_hi_o(hi4), .prod_lo_o(lo4));

    // {multiplicand, multiplier, expected product}
    localparam logic [31:0] VEC [10] = '{
        {8'h02, 8'h07, 16'h000E},
        {8'h02, 8'hFD, 16'hFFFA},
        {8'h80, 8'h80, 16'h4000},
        {8'h80, 8'h7F, 16'hC080},
        {8'h7F, 8'h7F, 16'h3F01},
        {8'hFF, 8'hFF, 16'h0001},
        {8'h00, 8'hB3, 16'h0000},
        {8'h55, 8'hAA, 16'hE372},
        {8'hFF, 8'h7F, 16'hFF81},
        {8'h01, 8'h80, 16'hFF80}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Starts a run at width 8; optionally pulses start again mid-run with other operands.
    task automatic run8(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2*W-1:0] exp, input bit poke, input string req);
        int cyc = 0;
        @(negedge clk);
        a8 = a; b8 = b; start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        check(busy8 === 1'b1, "R6 busy after start", 32'(busy8), 32'd1);
        while (busy8 === 1'b1 && cyc < 4 * W) begin
            cyc++;
            if (poke && cyc == 3) begin
                a8 = ~a; b8 = 8'h5A; start8 = 1'b1;
            end
            @(negedge clk);
            start8 = 1'b0;
        end
        check(cyc == W, "R7 busy length", 32'(cyc), 32'(W));
        check(done8 === 1'b1, "R7 done pulse", 32'(done8), 32'd1);
        check({hi8, lo8} === exp, req, 32'({hi8, lo8}), 32'(exp));
        @(negedge clk);
        check(done8 === 1'b0, "R7 done single cycle", 32'(done8), 32'd0);
    endtask

    task automatic run4(input logic [W4-1:0] a, input logic [W4-1:0] b, input logic [2*W4-1:0] exp);
        int cyc = 0;
        @(negedge clk);
        a4 = a; b4 = b; start4 = 1'b1;
        @(negedge clk);
        start4 = 1'b0;
        while (busy4 === 1'b1 && cyc < 4 * W4) begin
            cyc++;
            @(negedge clk);
        end
        check(cyc == W4 && done4 === 1'b1, "R10 4-bit timing", 32'(cyc), 32'(W4));
        check({hi4, lo4} === exp, "R10 4-bit product", 32'({hi4, lo4}), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy8 === 1'b0 && done8 === 1'b0, "R1 flags in reset", {busy8, done8}, 32'd0);
        check({hi8, lo8} === 16'h0, "R1 product in reset", 32'({hi8, lo8}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({hi8, lo8, busy8, done8} === '0, "R1 state after reset", 32'({hi8, lo8}), 32'd0);

        // R2 R3 R4 R5 R9: table of signed products (R5 covers the -128 rows)
        for (int i = 0; i < 10; i++) begin
            run8(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], 1'b0, "R2/R3/R4/R5 product");
        end

        // R9: product held while idle, operands wiggle without start
        a8 = 8'h33; b8 = 8'hC1;
        repeat (5) @(negedge clk);
        check({hi8, lo8} === 16'hFF80, "R9 hold while idle", 32'({hi8, lo8}), 32'hFF80);
        check(hi8 === 8'hFF && lo8 === 8'h80, "R9 half split", 32'({hi8, lo8}), 32'hFF80);

        // R8: start strobe during a run is ignored; 3 x 5 = 15
        run8(8'h03, 8'h05, 16'h000F, 1'b1, "R8 start ignored while busy");

        // R6: a fresh start after completion is accepted; -7 x 9 = -63
        run8(8'hF9, 8'h09, 16'hFFC1, 1'b0, "R6 restart accepted");

        // R10: narrow instance
        run4(4'h2, 4'h7, 8'h0E);
        run4(4'h2, 4'hD, 8'hFA);
        run4(4'h8, 4'h8, 8'h40);

        summary();
    end
endmodule